// File: doc/BRIEF.md
# Width-Selectable Byte FIFO with Level Watermarks

This block is a 256-byte first-in first-out buffer for one direction of a serial controller. One side pushes entries and the other side pops them; on a transmit path the register bus pushes and the shift engine pops, and on a receive path the roles swap. The same storage holds 256 byte entries, 128 halfword entries or 64 word entries, depending on a width setting. The level is always counted in entries.

Operation is gated by a run input and a flush input. While the run input is low, pushes and pops have no effect. A flush empties the buffer at once.

Besides its full and empty flags and a packed status word, the block compares its level against a programmable threshold and against three 6-bit watermarks: stop, low and high. The watermarks count in 4-byte units. The resulting flags feed the controller's interrupt logic.

Top module: `multiwidth_fifo`

## Requirements
- R1: After reset the buffer is empty: the status word reads 0x200 (empty set, full clear, level 0).
- R2: The width input selects the entry size: 0 means 1 byte (256 entries), 1 means 2 bytes (128 entries), and 2 or 3 means 4 bytes (64 entries). The full flag is set once that many entries are held.
- R3: A push while full and a pop while empty are ignored. The level and the stored contents stay unchanged.
- R4: Entries leave in the order they were pushed. The output shows the oldest entry, taken from the low bits of the pushed word and zero-extended. Input bits above the entry size are dropped.
- R5: The status word has the level in entries in bits 7:0, full in bit 8 and empty in bit 9. With byte entries and a full buffer, the level field reads 0.
- R6: The level, full and empty flags, the threshold flag and the watermark flags change on the clock edge that accepts a push or pop. They are visible in the cycle after that edge.
- R7: While the run input is low, pushes and pops are ignored.
- R8: A flush empties the buffer on the next edge. It takes priority over a push or pop in the same cycle.
- R9: The threshold flag is high when the level in entries is at least the 8-bit threshold value.
- R10: Let the held byte count divided by 4 (rounded down) be the word level. The stop flag is high when the word level equals the stop value. The low flag is high when it is at or below the low value. The high flag is high when it is at or above the high value.
- R11: A push and a pop accepted in the same cycle leave the level unchanged and both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_flush | input | 1 | Empty the buffer |
| op_run | input | 1 | Enables pushes and pops |
| cfg_width | input | 2 | Entry size select |
| cfg_thresh | input | 8 | Threshold, in entries |
| wm_stop | input | 6 | Stop watermark, in words |
| wm_low | input | 6 | Low watermark, in words |
| wm_high | input | 6 | High watermark, in words |
| push_en | input | 1 | Push request |
| push_data | input | 32 | Entry to push, low-aligned |
| pop_en | input | 1 | Pop request |
| pop_data | output | 32 | Oldest entry, zero-extended |
| status | output | 10 | {empty, full, level[7:0]} |
| thr_hit | output | 1 | Level at or above threshold |
| wm_stop_hit | output | 1 | Word level equals stop value |
| wm_low_hit | output | 1 | Word level at or below low value |
| wm_high_hit | output | 1 | Word level at or above high value |

## Verification
The assertions assume the entry width is only changed while the buffer is empty. They also assume that flush is never asserted during reset. Byte counts stay a multiple of the entry size only under the first condition, and the flags only match the count under both. The bench keeps to this by changing the width only right after a flush. It holds every input steady from one falling edge to the next. It drives push and pop into full, empty, stopped and flushing states on purpose, to exercise the ignored cases.

// File: rtl/multiwidth_fifo.sv
module multiwidth_fifo #(
  parameter int CAP_BYTES = 256,
  parameter int DW        = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_flush,
  input  logic          op_run,
  input  logic [1:0]    cfg_width,
  input  logic [7:0]    cfg_thresh,
  input  logic [5:0]    wm_stop,
  input  logic [5:0]    wm_low,
  input  logic [5:0]    wm_high,
  input  logic          push_en,
  input  logic [DW-1:0] push_data,
  input  logic          pop_en,
  output logic [DW-1:0] pop_data,
  output logic [9:0]    status,
  output logic          thr_hit,
  output logic          wm_stop_hit,
  output logic          wm_low_hit,
  output logic          wm_high_hit
);
  localparam int AW = $clog2(CAP_BYTES);
  localparam int CW = AW + 1;
  localparam int NB = DW / 8;

  logic [7:0]    mem [CAP_BYTES];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nxt, lvl_ent, lvl_dw;
  logic          full_q, empty_q;
  logic [1:0]    sh;
  logic [2:0]    nb;

  always_comb begin
    case (cfg_width)
      2'd0:    sh = 2'd0;
      2'd1:    sh = 2'd1;
      default: sh = 2'd2;
    endcase
  end
  assign nb = 3'd1 << sh;

  wire push_ok = op_run & push_en & ~full_q  & ~op_flush;
  wire pop_ok  = op_run & pop_en  & ~empty_q & ~op_flush;

  always_comb begin
    cnt_nxt = cnt;
    if (push_ok) cnt_nxt = cnt_nxt + CW'(nb);
    if (pop_ok)  cnt_nxt = cnt_nxt - CW'(nb);
    if (op_flush) cnt_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      cnt     <= cnt_nxt;
      full_q  <= ({1'b0, cnt_nxt} + (CW+1)'(nb)) > (CW+1)'(CAP_BYTES);
      empty_q <= cnt_nxt < CW'(nb);
      if (op_flush) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (push_ok) wp <= wp + AW'(nb);
        if (pop_ok)  rp <= rp + AW'(nb);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NB; i++)
      if (push_ok && 3'(i) < nb)
        mem[wp + AW'(i)] <= push_data[8*i +: 8];
  end

  always_comb begin
    for (int i = 0; i < NB; i++)
      pop_data[8*i +: 8] = (3'(i) < nb) ? mem[rp + AW'(i)] : 8'h00;
  end

  assign lvl_ent     = cnt >> sh;
  assign lvl_dw      = cnt >> 2;
  assign status      = {empty_q, full_q, 8'(lvl_ent)};
  assign thr_hit     = lvl_ent >= CW'(cfg_thresh);
  assign wm_stop_hit = lvl_dw == CW'(wm_stop);
  assign wm_low_hit  = lvl_dw <= CW'(wm_low);
  assign wm_high_hit = lvl_dw >= CW'(wm_high);

  a_r5_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && empty_q));
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && push_en && !pop_en && !op_flush) |=> $stable(cnt) && $stable(wp));
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_q && pop_en && !push_en && !op_flush) |=> $stable(cnt) && $stable(rp));
  a_r7_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_run && !op_flush) |=> $stable(cnt) && $stable(wp) && $stable(rp));
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    op_flush |=> (cnt == '0) && empty_q);
  a_r11_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
    (op_run && push_en && pop_en && !full_q && !empty_q && !op_flush) |=> $stable(cnt));
  a_r6_full_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !pop_en && !op_flush) |=> full_q || $changed(cfg_width));
endmodule

// File: tb/multiwidth_fifo_test.sv
module multiwidth_fifo_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, op_flush = 0, op_run = 0;
  logic [1:0]  cfg_width = 2'd2;
  logic [7:0]  cfg_thresh = 8'd32;
  logic [5:0]  wm_stop = 6'd10, wm_low = 6'd8, wm_high = 6'd40;
  logic        push_en = 0, pop_en = 0;
  logic [31:0] push_data = '0, pop_data;
  logic [9:0]  status;
  logic        thr_hit, wm_stop_hit, wm_low_hit, wm_high_hit;

  int tests = 0, fails = 0, m_cnt = 0;
  logic [31:0] exp_q[$];

  multiwidth_fifo uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int bpe();
    return (cfg_width == 2'd0) ? 1 : (cfg_width == 2'd1) ? 2 : 4;
  endfunction
  function automatic int cap();
    return 256 / bpe();
  endfunction
  function automatic logic [31:0] msk();
    return (cfg_width == 2'd0) ? 32'hFF : (cfg_width == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_state();
    logic [9:0] es;
    int dw;
    es = {m_cnt == 0, m_cnt == cap(), 8'(m_cnt)};
    dw = (m_cnt * bpe()) / 4;
    check(status == es, "R5/R6 status", status, es);
    check(thr_hit == (m_cnt >= int'(cfg_thresh)), "R9 threshold", thr_hit, m_cnt >= int'(cfg_thresh));
    check(wm_stop_hit == (dw == int'(wm_stop)), "R10 stop", wm_stop_hit, dw == int'(wm_stop));
    check(wm_low_hit == (dw <= int'(wm_low)), "R10 low", wm_low_hit, dw <= int'(wm_low));
    check(wm_high_hit == (dw >= int'(wm_high)), "R10 high", wm_high_hit, dw >= int'(wm_high));
  endtask

  task automatic do_op(input bit pu, input bit po, input logic [31:0] d);
    bit pu_ok, po_ok;
    @(negedge clk);
    push_en = pu; pop_en = po; push_data = d;
    pu_ok = op_run && pu && (m_cnt < cap());
    po_ok = op_run && po && (m_cnt > 0);
    #1;
    if (po_ok) check(pop_data == exp_q[0], "R4 pop data", pop_data, exp_q[0]);
    @(negedge clk);
    push_en = 0; pop_en = 0;
    if (po_ok) begin void'(exp_q.pop_front()); m_cnt--; end
    if (pu_ok) begin exp_q.push_back(d & msk()); m_cnt++; end
    check_state();
  endtask

  task automatic flush_with_push();
    @(negedge clk);
    op_flush = 1; push_en = 1; push_data = 32'h5A5A5A5A;
    @(negedge clk);
    op_flush = 0; push_en = 0;
    exp_q.delete(); m_cnt = 0;
    check(status == 10'h200, "R8 flush", status, 10'h200);
    check_state();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(status == 10'h200, "R1 reset status", status, 10'h200);
    op_run = 1;

    // R2 R4 word entries, fill, overflow, drain, underflow
    for (int i = 0; i < 64; i++) do_op(1, 0, 32'hC0DE0000 + i);
    check(status == 10'h140, "R2 word full", status, 10'h140);
    do_op(1, 0, 32'hDEADBEEF);                      // R3 ignored push
    for (int i = 0; i < 64; i++) do_op(0, 1, 0);
    do_op(0, 1, 0);                                 // R3 ignored pop
    check(status == 10'h200, "R3 empty after underflow", status, 10'h200);

    // R2 R5 byte entries; full reads level 0
    flush_with_push();
    cfg_width = 2'd0; cfg_thresh = 8'd128;
    @(negedge clk);
    for (int i = 0; i < 256; i++) do_op(1, 0, 32'hABCDEF00 + i);
    check(status == 10'h100, "R5 byte full level field", status, 10'h100);
    do_op(1, 0, 32'h77);                            // R3
    for (int i = 0; i < 10; i++) do_op(0, 1, 0);
    do_op(1, 1, 32'h1234_56EE);                     // R11
    check(status[7:0] == 8'd246, "R11 level kept", status[7:0], 246);

    // R2 halfword entries
    flush_with_push();
    cfg_width = 2'd1; cfg_thresh = 8'd100;
    @(negedge clk);
    for (int i = 0; i < 128; i++) do_op(1, 0, 32'hFACE0000 | (i * 257));
    check(status == 10'h180, "R2 halfword full", status, 10'h180);
    for (int i = 0; i < 128; i++) do_op(0, 1, 0);

    // R2 width code 3 acts as word
    flush_with_push();
    cfg_width = 2'd3;
    @(negedge clk);
    for (int i = 0; i < 64; i++) do_op(1, 0, 32'h11110000 + i);
    check(status == 10'h140, "R2 code 3 full", status, 10'h140);
    for (int i = 0; i < 30; i++) do_op(0, 1, 0);

    // R7 stopped
    op_run = 0;
    do_op(1, 0, 32'h99);
    do_op(0, 1, 0);
    check(status[7:0] == 8'd34, "R7 stopped level", status[7:0], 34);
    op_run = 1;
    for (int i = 0; i < 5; i++) do_op(1, 1, 32'h2000 + i);
    for (int i = 0; i < 34; i++) do_op(0, 1, 0);
    flush_with_push();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule